// File: doc/BRIEF.md
# Dual-Protocol Parallel Host Register Port

This block is the host-facing side of an audio processor. An external controller reaches it over an 8-bit parallel bus that carries a 2-bit register address. It reaches four registers: a message register that carries control bytes in both directions, a control/status register, and two write-only streaming registers. Bytes written to the streaming registers go straight into two internal byte FIFOs, one for PCM samples and one for compressed audio. A mode input selects the bus protocol. In the first protocol, reads and writes have separate strobes. In the second, a single data strobe works together with a read/write select.

The host strobes are asynchronous. Each one passes through a two-flop synchronizer. A small state machine per port (states `IDLE`, `RD_ACT`, `WR_ACT`) then turns each access into a single-cycle event on the strobe's trailing edge. The transitions are:
- `IDLE->RD_ACT` on a read request.
- `IDLE->WR_ACT` on a write request.
- `RD_ACT->IDLE` and `WR_ACT->IDLE` when the request ends. The access takes effect here.
- `any->IDLE` at once when the port is turned off.

The control register shows whether the core can take another message byte and whether an outgoing byte is waiting. It also carries a threshold-reached flag and a sticky overflow flag for each FIFO. The data pins are shared with an external memory interface, so the port works only while external memory is turned off.

Top module: `hpi_regport`

## Requirements
- R1: Address map: 00 = message, 01 = control, 10 = compressed data, 11 = PCM data. The control byte reads `{2'b00, cmp_ovf, pcm_ovf, cmp_hit, pcm_hit, out_avail, in_ready}` (bit 0 = in_ready).
- R2: With `bus_mode`=0, a low `rd_n` is a read and a low `wr_n` is a write. The access acts when the strobe rises, within 4 clock cycles of that edge.
- R3: With `bus_mode`=1, a low `ds_n` starts an access. `rnw`=1 makes it a read and `rnw`=0 a write. The access acts when `ds_n` rises.
- R4: A host write to the message register presents the byte on `core_rx_data` with `core_rx_valid`=1 and clears in_ready. in_ready returns to 1 only after `core_rx_take`. A message write made while in_ready=0 is dropped.
- R5: A message read returns the waiting outgoing byte and clears out_avail at the end of the access. It returns 0x00 when no byte is waiting.
- R6: A write to address 11 pushes onto the PCM FIFO and a write to address 10 pushes onto the compressed FIFO. The bytes come out in order at `pcm_data`/`cmp_data` and are removed by `pcm_pop`/`cmp_pop`. A read of either address returns 0x00 and changes nothing.
- R7: pcm_hit is 1 exactly when the PCM fill level is at least `pcm_thresh`, and cmp_hit likewise for the compressed FIFO. Each flag follows its level every cycle and clears when the level falls below the threshold.
- R8: A write to a full FIFO (depth `FIFO_DEPTH`) is dropped and sets that FIFO's sticky overflow bit. Writing 1 to bit 4 (PCM) or bit 5 (compressed) of the control register clears that bit. No other control write has any effect.
- R9: While `ext_mem_en`=1, strobes are ignored and `rdata_oe` stays 0.
- R10: After reset the control register reads 0x01 (given thresholds of at least 1), both FIFOs are empty, and `rdata_oe` is 0.
- R11: `core_tx_load` takes `core_tx_data` only while `core_tx_ready` (the inverse of out_avail) is 1. A load while a byte is waiting is ignored.
- R12: `rdata_oe` is 1 only during a read access. `rd_done` and `wr_done` never pulse together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_mode | input | 1 | 0 = separate read/write strobes, 1 = single strobe plus read/write select |
| ext_mem_en | input | 1 | External memory owns the data pins; port disabled |
| addr | input | 2 | Register address |
| rd_n | input | 1 | Read strobe, active low (mode 0) |
| wr_n | input | 1 | Write strobe, active low (mode 0) |
| ds_n | input | 1 | Data strobe, active low (mode 1) |
| rnw | input | 1 | 1 = read, 0 = write (mode 1) |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data |
| rdata_oe | output | 1 | Drive enable for the read data |
| core_rx_data | output | 8 | Message byte from the host |
| core_rx_valid | output | 1 | A host message byte is waiting for the core |
| core_rx_take | input | 1 | Core consumes the host message byte |
| core_tx_data | input | 8 | Outgoing message byte from the core |
| core_tx_load | input | 1 | Core offers an outgoing byte |
| core_tx_ready | output | 1 | Outgoing slot is free |
| pcm_thresh | input | FIFO_LW | PCM FIFO threshold |
| cmp_thresh | input | FIFO_LW | Compressed FIFO threshold |
| pcm_pop | input | 1 | Remove the head of the PCM FIFO |
| pcm_data | output | 8 | Head of the PCM FIFO |
| pcm_empty | output | 1 | PCM FIFO empty |
| cmp_pop | input | 1 | Remove the head of the compressed FIFO |
| cmp_data | output | 8 | Head of the compressed FIFO |
| cmp_empty | output | 1 | Compressed FIFO empty |

## Verification
The bench fills each FIFO one byte at a time. At every fill level it sweeps the threshold over its whole range and compares the hit flag with the level-against-threshold comparison. An off-by-one comparator would move the flag one level early or late. The ninth write to a full FIFO must leave the FIFO contents unchanged and set only that FIFO's overflow bit. A design that wraps its pointers would corrupt the pop order, and one that clears the bit on its own would lose the sticky flag. Message writes made while the core has not taken the previous byte, core loads made while a byte is waiting, reads of the write-only registers, and strobes made while external memory owns the pins must all leave the visible state unchanged. A design that lets these through would overwrite bytes, pop bytes by accident, or drive the shared bus.

// File: rtl/hpi_pkg.sv
package hpi_pkg;
    localparam logic [1:0] ADDR_MSG  = 2'b00;
    localparam logic [1:0] ADDR_CTRL = 2'b01;
    localparam logic [1:0] ADDR_CMP  = 2'b10;
    localparam logic [1:0] ADDR_PCM  = 2'b11;

    typedef enum logic [1:0] {
        IDLE   = 2'd0,
        RD_ACT = 2'd1,
        WR_ACT = 2'd2
    } acc_state_t;
endpackage

// File: rtl/hpi_strobe_dec.sv
module hpi_strobe_dec
    import hpi_pkg::*;
#(
    parameter int AW = 2,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_mode,
    input  logic          port_off,
    input  logic [AW-1:0] addr,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic          ds_n,
    input  logic          rnw,
    input  logic [DW-1:0] wdata,
    output logic          rd_active,
    output logic          rd_done,
    output logic          wr_done,
    output logic [AW-1:0] acc_addr,
    output logic [DW-1:0] acc_data
);
    logic [1:0] rd_sy, wr_sy, ds_sy, rnw_sy;
    logic       rd_req, wr_req;
    acc_state_t state, nxt;

    // two-flop synchronizers, reset to the idle (high) level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_sy  <= 2'b11;
            wr_sy  <= 2'b11;
            ds_sy  <= 2'b11;
            rnw_sy <= 2'b11;
        end else begin
            rd_sy  <= {rd_sy[0], rd_n};
            wr_sy  <= {wr_sy[0], wr_n};
            ds_sy  <= {ds_sy[0], ds_n};
            rnw_sy <= {rnw_sy[0], rnw};
        end
    end

    always_comb begin
        if (bus_mode) begin
            rd_req = !ds_sy[1] &&  rnw_sy[1];
            wr_req = !ds_sy[1] && !rnw_sy[1];
        end else begin
            rd_req = !rd_sy[1] &&  wr_sy[1];
            wr_req = !wr_sy[1] &&  rd_sy[1];
        end
    end

    always_comb begin
        nxt = state;
        if (port_off) begin
            nxt = IDLE;
        end else begin
            unique case (state)
                IDLE:    if (rd_req) nxt = RD_ACT;
                         else if (wr_req) nxt = WR_ACT;
                RD_ACT:  if (!rd_req) nxt = IDLE;
                WR_ACT:  if (!wr_req) nxt = IDLE;
                default: nxt = IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= IDLE;
        else        state <= nxt;
    end

    // outputs: trailing-edge pulses and access capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_done  <= 1'b0;
            wr_done  <= 1'b0;
            acc_addr <= '0;
            acc_data <= '0;
        end else begin
            rd_done <= !port_off && (state == RD_ACT) && (nxt == IDLE);
            wr_done <= !port_off && (state == WR_ACT) && (nxt == IDLE);
            if (rd_req || wr_req) begin
                acc_addr <= addr;
                acc_data <= wdata;
            end
        end
    end

    assign rd_active = (state == RD_ACT);
endmodule

// File: rtl/hpi_byte_fifo.sv
module hpi_byte_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          full,
    output logic          empty,
    output logic [LW-1:0] level
);
    localparam logic [PW-1:0] LAST  = PW'(DEPTH - 1);
    localparam logic [LW-1:0] LFULL = LW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (level == LFULL);
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
            level <= level + LW'(do_push) - LW'(do_pop);
        end
    end
endmodule

// File: rtl/hpi_regport.sv
module hpi_regport
    import hpi_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    localparam int FIFO_LW   = $clog2(FIFO_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_mode,
    input  logic               ext_mem_en,
    input  logic [1:0]         addr,
    input  logic               rd_n,
    input  logic               wr_n,
    input  logic               ds_n,
    input  logic               rnw,
    input  logic [7:0]         wdata,
    output logic [7:0]         rdata,
    output logic               rdata_oe,
    output logic [7:0]         core_rx_data,
    output logic               core_rx_valid,
    input  logic               core_rx_take,
    input  logic [7:0]         core_tx_data,
    input  logic               core_tx_load,
    output logic               core_tx_ready,
    input  logic [FIFO_LW-1:0] pcm_thresh,
    input  logic [FIFO_LW-1:0] cmp_thresh,
    input  logic               pcm_pop,
    output logic [7:0]         pcm_data,
    output logic               pcm_empty,
    input  logic               cmp_pop,
    output logic [7:0]         cmp_data,
    output logic               cmp_empty
);
    localparam int NCH = 2; // channel 0 = compressed (10), channel 1 = PCM (11)

    logic             rd_active, rd_done, wr_done;
    logic [1:0]       acc_addr;
    logic [7:0]       acc_data;
    logic             in_ready, out_avail;
    logic [7:0]       rx_byte, tx_byte;
    logic [NCH-1:0]   ovf, hit, f_push, f_pop, f_full, f_empty;
    logic [7:0]       f_dout [NCH];
    logic [FIFO_LW-1:0] f_lvl [NCH];
    logic [FIFO_LW-1:0] f_thr [NCH];
    logic [7:0]       ctrl_byte;

    hpi_strobe_dec #(.AW(2), .DW(8)) dec_i (
        .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .port_off(ext_mem_en),
        .addr(addr), .rd_n(rd_n), .wr_n(wr_n), .ds_n(ds_n), .rnw(rnw),
        .wdata(wdata), .rd_active(rd_active), .rd_done(rd_done),
        .wr_done(wr_done), .acc_addr(acc_addr), .acc_data(acc_data)
    );

    assign f_thr[0] = cmp_thresh;
    assign f_thr[1] = pcm_thresh;
    assign f_pop    = {pcm_pop, cmp_pop};

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        assign f_push[ch] = wr_done && acc_addr[1] && (acc_addr[0] == ch[0]);

        hpi_byte_fifo #(.DW(8), .DEPTH(FIFO_DEPTH)) fifo_i (
            .clk(clk), .rst_n(rst_n), .push(f_push[ch]), .din(acc_data),
            .pop(f_pop[ch]), .dout(f_dout[ch]), .full(f_full[ch]),
            .empty(f_empty[ch]), .level(f_lvl[ch])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hit[ch] <= 1'b0;
                ovf[ch] <= 1'b0;
            end else begin
                hit[ch] <= (f_lvl[ch] >= f_thr[ch]);
                if (f_push[ch] && f_full[ch])
                    ovf[ch] <= 1'b1;
                else if (wr_done && acc_addr == ADDR_CTRL && acc_data[5 - ch])
                    ovf[ch] <= 1'b0;
            end
        end
    end

    assign cmp_data  = f_dout[0];
    assign pcm_data  = f_dout[1];
    assign cmp_empty = f_empty[0];
    assign pcm_empty = f_empty[1];

    // message channel
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_ready  <= 1'b1;
            out_avail <= 1'b0;
            rx_byte   <= '0;
            tx_byte   <= '0;
        end else begin
            if (wr_done && acc_addr == ADDR_MSG && in_ready) begin
                rx_byte  <= acc_data;
                in_ready <= 1'b0;
            end else if (core_rx_take) begin
                in_ready <= 1'b1;
            end
            if (rd_done && acc_addr == ADDR_MSG) begin
                out_avail <= 1'b0;
            end else if (core_tx_load && !out_avail) begin
                tx_byte   <= core_tx_data;
                out_avail <= 1'b1;
            end
        end
    end

    assign core_rx_data  = rx_byte;
    assign core_rx_valid = !in_ready;
    assign core_tx_ready = !out_avail;

    assign ctrl_byte = {2'b00, ovf[0], ovf[1], hit[0], hit[1], out_avail, in_ready};

    always_comb begin
        unique case (addr)
            ADDR_MSG:  rdata = out_avail ? tx_byte : 8'h00;
            ADDR_CTRL: rdata = ctrl_byte;
            default:   rdata = 8'h00;
        endcase
    end

    assign rdata_oe = rd_active && !ext_mem_en;
endmodule

// File: rtl/hpi_regport_chk.sv
module hpi_regport_chk #(
    parameter int FIFO_DEPTH = 8,
    localparam int FIFO_LW   = $clog2(FIFO_DEPTH + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ext_mem_en,
    input logic               rdata_oe,
    input logic               rd_done,
    input logic               wr_done,
    input logic [1:0]         acc_addr,
    input logic [7:0]         acc_data,
    input logic               in_ready,
    input logic               out_avail,
    input logic               core_rx_take,
    input logic [1:0]         ovf,
    input logic [1:0]         f_push,
    input logic [1:0]         f_full,
    input logic [FIFO_LW-1:0] pcm_lvl,
    input logic [FIFO_LW-1:0] cmp_lvl
);
    // R9
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_mem_en |-> !rdata_oe);

    // R12
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_done && wr_done));

    // R4
    in_ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ready) |-> $past(core_rx_take));

    // R5
    out_avail_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_avail) |-> $past(rd_done && acc_addr == 2'b00));

    // R8
    pcm_ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf[1] && !(wr_done && acc_addr == 2'b01 && acc_data[4])) |=> ovf[1]);

    // R8
    cmp_ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (f_push[0] && f_full[0]) |=> ovf[0]);

    // R6
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pcm_lvl <= FIFO_LW'(FIFO_DEPTH)) && (cmp_lvl <= FIFO_LW'(FIFO_DEPTH)));
endmodule

bind hpi_regport hpi_regport_chk #(.FIFO_DEPTH(FIFO_DEPTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .ext_mem_en(ext_mem_en), .rdata_oe(rdata_oe),
    .rd_done(rd_done), .wr_done(wr_done), .acc_addr(acc_addr),
    .acc_data(acc_data), .in_ready(in_ready), .out_avail(out_avail),
    .core_rx_take(core_rx_take), .ovf(ovf), .f_push(f_push), .f_full(f_full),
    .pcm_lvl(f_lvl[1]), .cmp_lvl(f_lvl[0])
);

// File: tb/hpi_regport_tb.sv
module hpi_regport_tb_top;
    localparam int DEPTH = 8;
    localparam int LW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_mode = 1'b0, ext_mem_en = 1'b0;
    logic [1:0] addr = '0;
    logic rd_n = 1'b1, wr_n = 1'b1, ds_n = 1'b1, rnw = 1'b1;
    logic [7:0] wdata = '0, rdata, core_rx_data, core_tx_data = '0, pcm_data, cmp_data;
    logic rdata_oe, core_rx_valid, core_rx_take = 1'b0, core_tx_load = 1'b0, core_tx_ready;
    logic [LW-1:0] pcm_thresh = LW'(1), cmp_thresh = LW'(1);
    logic pcm_pop = 1'b0, cmp_pop = 1'b0, pcm_empty, cmp_empty;

    int n_chk = 0, n_err = 0;
    logic [7:0] rb;
    logic       roe;

    always #10 clk = ~clk;

    hpi_regport #(.FIFO_DEPTH(DEPTH)) dut_i (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d;
        if (bus_mode) begin rnw = 1'b0; ds_n = 1'b0; end else wr_n = 1'b0;
        cyc(4);
        ds_n = 1'b1; wr_n = 1'b1;
        cyc(6);
        rnw = 1'b1;
    endtask

    task automatic host_rd(input logic [1:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk);
        addr = a;
        if (bus_mode) begin rnw = 1'b1; ds_n = 1'b0; end else rd_n = 1'b0;
        cyc(4);
        d = rdata; oe = rdata_oe;
        ds_n = 1'b1; rd_n = 1'b1;
        cyc(6);
    endtask

    initial begin
        cyc(200000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(3);
        // R10 reset state
        chk("R10 rdata_oe", rdata_oe, 0);
        chk("R10 pcm_empty", pcm_empty, 1);
        chk("R10 cmp_empty", cmp_empty, 1);
        host_rd(2'b01, rb, roe);
        chk("R10 ctrl after reset", rb, 8'h01);
        chk("R12 oe during read", roe, 1);
        cyc(1);
        chk("R12 oe after read", rdata_oe, 0);

        // R4 message write, R2 separate strobes
        host_wr(2'b00, 8'h5A);
        chk("R4 rx_valid", core_rx_valid, 1);
        chk("R4 rx_data", core_rx_data, 8'h5A);
        host_wr(2'b00, 8'h77);
        chk("R4 dropped write", core_rx_data, 8'h5A);
        host_rd(2'b01, rb, roe);
        chk("R1 ctrl in_ready bit0 clear", rb[0], 0);
        @(negedge clk); core_rx_take = 1'b1; @(negedge clk); core_rx_take = 1'b0;
        chk("R4 released", core_rx_valid, 0);

        // R11 / R5 outgoing message
        @(negedge clk); core_tx_data = 8'hC3; core_tx_load = 1'b1;
        @(negedge clk); core_tx_data = 8'h11;
        @(negedge clk); core_tx_load = 1'b0;
        chk("R11 tx_ready low", core_tx_ready, 0);
        host_rd(2'b01, rb, roe);
        chk("R5 out_avail bit1", rb[1:0], 2'b11);
        host_rd(2'b00, rb, roe);
        chk("R11 second load ignored, R5 read", rb, 8'hC3);
        chk("R5 out_avail cleared", core_tx_ready, 1);
        host_rd(2'b00, rb, roe);
        chk("R5 empty reads zero", rb, 8'h00);

        // R7 PCM threshold sweep, R6 pushes, bus_mode 0
        for (int k = 0; k <= DEPTH; k++) begin
            if (k > 0) host_wr(2'b11, 8'(k * 7 + 3));
            for (int t = 0; t <= DEPTH; t++) begin
                pcm_thresh = LW'(t);
                cyc(2);
                host_rd(2'b01, rb, roe);
                chk($sformatf("R7 pcm_hit k=%0d t=%0d", k, t), rb[2], (k >= t) ? 1 : 0);
                chk("R7 cmp_hit stays clear", rb[3], 0);
            end
        end
        pcm_thresh = LW'(1);
        // R6 read of data register has no effect
        host_rd(2'b11, rb, roe);
        chk("R6 data reg reads zero", rb, 8'h00);
        // R8 overflow
        host_wr(2'b11, 8'hEE);
        host_rd(2'b01, rb, roe);
        chk("R8 pcm ovf bit4", rb[5:4], 2'b01);
        host_wr(2'b01, 8'h20);
        host_rd(2'b01, rb, roe);
        chk("R8 other bit write no effect", rb[4], 1);
        for (int k = 1; k <= DEPTH; k++) begin
            chk("R6 pcm pop order", pcm_data, 8'(k * 7 + 3));
            @(negedge clk); pcm_pop = 1'b1; @(negedge clk); pcm_pop = 1'b0;
        end
        chk("R8 dropped byte absent", pcm_empty, 1);
        host_wr(2'b01, 8'h10);
        cyc(2);
        host_rd(2'b01, rb, roe);
        chk("R8 ovf cleared, R7 hit clear", rb, 8'h01);

        // R3 single strobe mode, compressed FIFO
        bus_mode = 1'b1;
        for (int k = 0; k <= DEPTH; k++) begin
            if (k > 0) host_wr(2'b10, 8'(8'hA0 ^ k));
            for (int t = 0; t <= DEPTH; t++) begin
                cmp_thresh = LW'(t);
                cyc(2);
                host_rd(2'b01, rb, roe);
                chk($sformatf("R3 R7 cmp_hit k=%0d t=%0d", k, t), rb[3], (k >= t) ? 1 : 0);
            end
        end
        cmp_thresh = LW'(1);
        host_wr(2'b10, 8'h55);
        host_rd(2'b01, rb, roe);
        chk("R8 cmp ovf bit5", rb[5:4], 2'b10);
        host_wr(2'b01, 8'h20);
        host_rd(2'b01, rb, roe);
        chk("R8 cmp ovf cleared", rb[5], 0);
        for (int k = 1; k <= DEPTH; k++) begin
            chk("R3 R6 cmp pop order", cmp_data, 8'(8'hA0 ^ k));
            @(negedge clk); cmp_pop = 1'b1; @(negedge clk); cmp_pop = 1'b0;
        end
        chk("R6 cmp drained", cmp_empty, 1);
        host_wr(2'b00, 8'h3C);
        chk("R3 R4 msg write", core_rx_data, 8'h3C);
        @(negedge clk); core_rx_take = 1'b1; @(negedge clk); core_rx_take = 1'b0;

        // R9 external memory owns the pins
        ext_mem_en = 1'b1;
        host_wr(2'b00, 8'h99);
        chk("R9 write ignored", core_rx_valid, 0);
        host_wr(2'b11, 8'h42);
        chk("R9 push ignored", pcm_empty, 1);
        host_rd(2'b01, rb, roe);
        chk("R9 not driven", roe, 0);
        ext_mem_en = 1'b0;
        cyc(2);
        host_rd(2'b01, rb, roe);
        chk("R9 ctrl after re-enable", rb, 8'h01);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule